// File: doc/BRIEF.md
# Multiply-Accumulate Tap Sequencer

This block runs a burst of signed multiply-accumulate taps for filter and correlation kernels. One start pulse brings in the whole job: a two-bit mode, an 8-bit repeat count, two start addresses and a circular buffer described by a base and a length. For each tap the sequencer reads two 16-bit operands through synchronous read ports with one cycle of latency. It multiplies them as signed numbers and adds the full product into an accumulator. When the last tap has been added it pulses `done`. The accumulator value stays on `acc_out` until the next job starts.

The mode picks two things. The first is the accumulator width and tap length: filter runs use 32 bits and 2 cycles per tap, and correlation runs use 48 bits and 3 cycles per tap. The second is where the second operand comes from: a coefficient store walked linearly, or a second data buffer walked in lockstep with the first. The controller is a six-state machine. IDLE moves to LOAD when start is accepted. LOAD issues the first read and moves to MUL. MUL captures the product and goes to HOLD in correlation runs, otherwise to ACC. HOLD goes to ACC. ACC goes back to MUL while taps remain, otherwise to DONE. DONE goes to IDLE.

Top module: `mac_tap_seq`

## Requirements
- R1: `mode[1]`=1 selects correlation and 0 selects filter. `mode[0]`=1 selects the dual-buffer source and 0 selects the coefficient source. A `tap_count` of N runs exactly N+2 taps.
- R2: Each tap forms the full signed 32-bit product of two 16-bit operands. The product is sign-extended before it is added.
- R3: In filter modes the sum wraps modulo 2^32, `acc_out[47:32]` reads zero, and each tap takes exactly 2 cycles.
- R4: In correlation modes the sum is kept in 48 bits, and each tap takes exactly 3 cycles.
- R5: In coefficient modes the first operand is read from port A at pointer A. The second is read from the coefficient port at pointer B, which steps by +2 per tap with no wrap (modulo 2^AW). `dmem_b_re` stays low.
- R6: In dual-buffer modes the second operand is read from port B at pointer B. Both pointers step by +2 per tap in lockstep. `cmem_re` stays low, and `dmem_b_re` pulses exactly once per tap.
- R7: A data pointer p advances to p+2. If that value is at or beyond base+len, it is reduced by len.
- R8: `done` is high for exactly one cycle, on the (T*C+1)-th rising edge after the edge that accepts start. Here T is the number of taps and C is the cycles per tap.
- R9: At start the accumulator clears unless `acc_continue` is high. When it is high, the new products add onto the previous result.
- R10: Start is accepted only in IDLE. A start pulse during a run changes neither the result nor the timing, and `busy` is high from LOAD through the last ACC.
- R11: After reset `busy`, `done`, all read enables and `acc_out` are zero.
- R12: Reads have one cycle of latency. The first read is issued in the cycle after the accepting edge, and each later read is issued in the final cycle of the previous tap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Job start pulse |
| mode | input | 2 | Bit 1 selects correlation, bit 0 selects dual buffer |
| acc_continue | input | 1 | Keep the accumulator at start |
| tap_count | input | CW | Repeat count N; the job runs N+2 taps |
| ptr_a_init | input | AW | Start address of the first data pointer |
| ptr_b_init | input | AW | Start address of the second data pointer or the coefficient pointer |
| buf_base | input | AW | Lowest address of the circular buffer |
| buf_len | input | AW | Length of the circular buffer |
| dmem_a_re | output | 1 | Read enable, data port A |
| dmem_a_addr | output | AW | Address, data port A |
| dmem_a_rdata | input | DW | Read data, port A, valid one cycle after the enable |
| dmem_b_re | output | 1 | Read enable, data port B |
| dmem_b_addr | output | AW | Address, data port B |
| dmem_b_rdata | input | DW | Read data, port B |
| cmem_re | output | 1 | Read enable, coefficient port |
| cmem_addr | output | AW | Address, coefficient port |
| cmem_rdata | input | DW | Read data, coefficient port |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |
| acc_out | output | 3*DW | Accumulator; the upper third is zero in filter modes |

## Verification
The assertions rely on the job's inputs being well formed. The start pointers must lie inside the buffer, the length must be at least 2, and base plus length must not exceed the address space. The memories must return data one cycle after each read enable. The bench picks a random base and an even length so that the buffer fits. It draws both start pointers from inside that buffer and holds none of the job inputs beyond the start cycle. It does change them during a run when it tests that start is ignored, and this is safe because the design latches them at acceptance.

// File: rtl/mac_tap_pkg.sv
package mac_tap_pkg;
    localparam int MODE_DUAL_BIT = 0;
    localparam int MODE_CORR_BIT = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_MUL,
        ST_HOLD,
        ST_ACC,
        ST_DONE
    } tap_state_t;
endpackage

// File: rtl/mac_ptr_step.sv
module mac_ptr_step #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          wrap_en,
    input  logic [AW-1:0] init,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    output logic [AW-1:0] ptr
);
    logic [AW:0] inc_w;
    logic [AW:0] limit_w;
    logic [AW:0] next_w;

    always_comb begin
        inc_w   = {1'b0, ptr} + (AW+1)'(2);
        limit_w = {1'b0, base} + {1'b0, len};
        if (wrap_en && (inc_w >= limit_w))
            next_w = inc_w - {1'b0, len};
        else
            next_w = inc_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= init;
        else if (step)
            ptr <= next_w[AW-1:0];
    end
endmodule

// File: rtl/mac_tap_ctrl.sv
module mac_tap_ctrl
    import mac_tap_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          corr,
    input  logic [CW-1:0] tap_count,
    output logic          accept,
    output logic          issue,
    output logic          capture,
    output logic          accumulate,
    output logic          busy,
    output logic          done
);
    localparam int TW = CW + 1;

    tap_state_t state_q, state_d;
    logic [TW-1:0] left_q;
    logic          last_tap;

    assign last_tap = (left_q == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // remaining-tap counter: holds taps still to run after the current one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            left_q <= '0;
        else if (accept)
            left_q <= {1'b0, tap_count} + TW'(1);
        else if (state_q == ST_ACC && !last_tap)
            left_q <= left_q - TW'(1);
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_LOAD;
            ST_LOAD: state_d = ST_MUL;
            ST_MUL:  state_d = corr ? ST_HOLD : ST_ACC;
            ST_HOLD: state_d = ST_ACC;
            ST_ACC:  state_d = last_tap ? ST_DONE : ST_MUL;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept     = 1'b0;
        issue      = 1'b0;
        capture    = 1'b0;
        accumulate = 1'b0;
        busy       = 1'b0;
        done       = 1'b0;
        unique case (state_q)
            ST_IDLE: accept = start;
            ST_LOAD: begin
                busy  = 1'b1;
                issue = 1'b1;
            end
            ST_MUL: begin
                busy    = 1'b1;
                capture = 1'b1;
            end
            ST_HOLD: busy = 1'b1;
            ST_ACC: begin
                busy       = 1'b1;
                accumulate = 1'b1;
                issue      = !last_tap;
            end
            ST_DONE: done = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mac_tap_dp.sv
module mac_tap_dp #(
    parameter int DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            capture,
    input  logic            accumulate,
    input  logic            corr,
    input  logic [DW-1:0]   op_a,
    input  logic [DW-1:0]   op_b,
    output logic [3*DW-1:0] acc_q
);
    localparam int PW   = 2 * DW;
    localparam int ACCW = 3 * DW;

    logic [PW-1:0]   prod_q;
    logic [PW-1:0]   ext_a, ext_b, prod_w;
    logic [ACCW-1:0] prod_sx;
    logic [PW-1:0]   short_sum;
    logic [ACCW-1:0] acc_d;

    always_comb begin
        ext_a     = {{DW{op_a[DW-1]}}, op_a};
        ext_b     = {{DW{op_b[DW-1]}}, op_b};
        prod_w    = ext_a * ext_b;
        prod_sx   = {{(ACCW-PW){prod_q[PW-1]}}, prod_q};
        short_sum = acc_q[PW-1:0] + prod_q;
        if (corr)
            acc_d = acc_q + prod_sx;
        else
            acc_d = {{(ACCW-PW){1'b0}}, short_sum};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prod_q <= '0;
        else if (capture)
            prod_q <= prod_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            acc_q <= '0;
        else if (clear)
            acc_q <= '0;
        else if (accumulate)
            acc_q <= acc_d;
    end
endmodule

// File: rtl/mac_tap_seq.sv
module mac_tap_seq
    import mac_tap_pkg::*;
#(
    parameter int DW = 16,
    parameter int AW = 8,
    parameter int CW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [1:0]      mode,
    input  logic            acc_continue,
    input  logic [CW-1:0]   tap_count,
    input  logic [AW-1:0]   ptr_a_init,
    input  logic [AW-1:0]   ptr_b_init,
    input  logic [AW-1:0]   buf_base,
    input  logic [AW-1:0]   buf_len,
    output logic            dmem_a_re,
    output logic [AW-1:0]   dmem_a_addr,
    input  logic [DW-1:0]   dmem_a_rdata,
    output logic            dmem_b_re,
    output logic [AW-1:0]   dmem_b_addr,
    input  logic [DW-1:0]   dmem_b_rdata,
    output logic            cmem_re,
    output logic [AW-1:0]   cmem_addr,
    input  logic [DW-1:0]   cmem_rdata,
    output logic            busy,
    output logic            done,
    output logic [3*DW-1:0] acc_out
);
    localparam int PW   = 2 * DW;
    localparam int ACCW = 3 * DW;
    localparam int NPTR = 2;

    logic            accept, issue, capture, accumulate;
    logic            cfg_corr, cfg_dual;
    logic [AW-1:0]   cfg_base, cfg_len;
    logic [AW-1:0]   ptr_init [NPTR];
    logic [AW-1:0]   ptr_q    [NPTR];
    logic            ptr_wrap [NPTR];
    logic [DW-1:0]   op_b;
    logic [ACCW-1:0] acc_q;

    // job configuration, sampled when start is accepted
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_corr <= 1'b0;
            cfg_dual <= 1'b0;
            cfg_base <= '0;
            cfg_len  <= '0;
        end else if (accept) begin
            cfg_corr <= mode[MODE_CORR_BIT];
            cfg_dual <= mode[MODE_DUAL_BIT];
            cfg_base <= buf_base;
            cfg_len  <= buf_len;
        end
    end

    mac_tap_ctrl #(.CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .corr       (cfg_corr),
        .tap_count  (tap_count),
        .accept     (accept),
        .issue      (issue),
        .capture    (capture),
        .accumulate (accumulate),
        .busy       (busy),
        .done       (done)
    );

    assign ptr_init[0] = ptr_a_init;
    assign ptr_init[1] = ptr_b_init;
    assign ptr_wrap[0] = 1'b1;
    assign ptr_wrap[1] = cfg_dual;

    for (genvar g = 0; g < NPTR; g++) begin : g_ptr
        mac_ptr_step #(.AW(AW)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (accept),
            .step    (capture),
            .wrap_en (ptr_wrap[g]),
            .init    (ptr_init[g]),
            .base    (cfg_base),
            .len     (cfg_len),
            .ptr     (ptr_q[g])
        );
    end

    assign dmem_a_re   = issue;
    assign dmem_a_addr = ptr_q[0];
    assign dmem_b_re   = issue && cfg_dual;
    assign dmem_b_addr = ptr_q[1];
    assign cmem_re     = issue && !cfg_dual;
    assign cmem_addr   = ptr_q[1];
    assign op_b        = cfg_dual ? dmem_b_rdata : cmem_rdata;

    mac_tap_dp #(.DW(DW)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (accept && !acc_continue),
        .capture    (capture),
        .accumulate (accumulate),
        .corr       (cfg_corr),
        .op_a       (dmem_a_rdata),
        .op_b       (op_b),
        .acc_q      (acc_q)
    );

    assign acc_out = cfg_corr ? acc_q : {{(ACCW-PW){1'b0}}, acc_q[PW-1:0]};
endmodule

// File: rtl/mac_tap_seq_chk.sv
module mac_tap_seq_chk #(
    parameter int AW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          done,
    input logic          dmem_a_re,
    input logic          dmem_b_re,
    input logic          cmem_re,
    input logic [AW-1:0] dmem_a_addr,
    input logic          cfg_corr,
    input logic [AW-1:0] cfg_base,
    input logic [AW-1:0] cfg_len
);
    logic [2:0] gap_q;
    logic       seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else begin
            if (dmem_a_re)
                gap_q <= 3'd1;
            else if (gap_q != 3'd7)
                gap_q <= gap_q + 3'd1;
            if (!busy)
                seen_q <= 1'b0;
            else if (dmem_a_re)
                seen_q <= 1'b1;
        end
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_run_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_run_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_tap_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_a_re && seen_q && !cfg_corr) |-> (gap_q == 3'd2));

    assert_tap_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dmem_a_re && seen_q && cfg_corr) |-> (gap_q == 3'd3));

    assert_addr_in_buffer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_a_re |-> ((dmem_a_addr >= cfg_base) &&
                       ({1'b0, dmem_a_addr} < ({1'b0, cfg_base} + {1'b0, cfg_len}))));

    assert_one_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dmem_b_re, cmem_re}));

    assert_quiet_when_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(dmem_a_re || dmem_b_re || cmem_re));
endmodule

bind mac_tap_seq mac_tap_seq_chk #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .busy        (busy),
    .done        (done),
    .dmem_a_re   (dmem_a_re),
    .dmem_b_re   (dmem_b_re),
    .cmem_re     (cmem_re),
    .dmem_a_addr (dmem_a_addr),
    .cfg_corr    (cfg_corr),
    .cfg_base    (cfg_base),
    .cfg_len     (cfg_len)
);

// File: tb/sim_mac_tap_seq.sv
`timescale 1ns/1ps
module sim_mac_tap_seq;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int CW = 8;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [1:0]    mode = '0;
    logic          acc_continue = 1'b0;
    logic [CW-1:0] tap_count = '0;
    logic [AW-1:0] ptr_a_init = '0, ptr_b_init = '0, buf_base = '0, buf_len = '0;
    logic          dmem_a_re, dmem_b_re, cmem_re;
    logic [AW-1:0] dmem_a_addr, dmem_b_addr, cmem_addr;
    logic [DW-1:0] dmem_a_rdata = '0, dmem_b_rdata = '0, cmem_rdata = '0;
    logic          busy, done;
    logic [47:0]   acc_out;

    logic [DW-1:0] dmem [DEPTH];
    logic [DW-1:0] cmem [DEPTH];

    int tests = 0;
    int fails = 0;
    int n_a = 0, n_b = 0, n_c = 0;
    int got_cyc;
    logic [47:0] got_acc;
    logic [47:0] prev_acc = '0;
    logic        first_re_ok;
    logic        done_width_ok;

    always #5 clk = ~clk;

    mac_tap_seq #(.DW(DW), .AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .acc_continue(acc_continue), .tap_count(tap_count),
        .ptr_a_init(ptr_a_init), .ptr_b_init(ptr_b_init),
        .buf_base(buf_base), .buf_len(buf_len),
        .dmem_a_re(dmem_a_re), .dmem_a_addr(dmem_a_addr), .dmem_a_rdata(dmem_a_rdata),
        .dmem_b_re(dmem_b_re), .dmem_b_addr(dmem_b_addr), .dmem_b_rdata(dmem_b_rdata),
        .cmem_re(cmem_re), .cmem_addr(cmem_addr), .cmem_rdata(cmem_rdata),
        .busy(busy), .done(done), .acc_out(acc_out)
    );

    // synchronous memories, one cycle of read latency
    always @(posedge clk) begin
        if (dmem_a_re) dmem_a_rdata <= dmem[dmem_a_addr];
        if (dmem_b_re) dmem_b_rdata <= dmem[dmem_b_addr];
        if (cmem_re)   cmem_rdata   <= cmem[cmem_addr];
        if (dmem_a_re) n_a <= n_a + 1;
        if (dmem_b_re) n_b <= n_b + 1;
        if (cmem_re)   n_c <= n_c + 1;
    end

    task automatic check(input string req, input string what,
                         input logic [63:0] got, input logic [63:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    function automatic logic [AW-1:0] wrap_step(input logic [AW-1:0] p,
                                                input logic [AW-1:0] b,
                                                input logic [AW-1:0] l);
        int v;
        v = int'(p) + 2;
        if (v >= int'(b) + int'(l)) v = v - int'(l);
        return AW'(v);
    endfunction

    function automatic logic [47:0] model(input logic [1:0] md, input int n,
                                          input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                                          input logic [AW-1:0] b, input logic [AW-1:0] l,
                                          input logic cont, input logic [47:0] prev);
        logic [47:0] acc;
        logic [AW-1:0] qa, qb;
        acc = cont ? prev : 48'd0;
        qa = pa;
        qb = pb;
        for (int i = 0; i < n + 2; i++) begin
            logic signed [15:0] sa, sb;
            longint pr;
            sa = dmem[qa];
            sb = md[0] ? dmem[qb] : cmem[qb];
            pr = longint'(sa) * longint'(sb);
            acc = acc + 48'(pr);
            if (!md[1]) acc = {16'd0, acc[31:0]};
            qa = wrap_step(qa, b, l);
            qb = md[0] ? wrap_step(qb, b, l) : AW'(qb + 2);
        end
        return acc;
    endfunction

    // runs one job; optionally pulses start again mid-run with other values
    task automatic run_job(input logic [1:0] md, input int n,
                           input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                           input logic [AW-1:0] b, input logic [AW-1:0] l,
                           input logic cont, input bit poke);
        @(negedge clk);
        n_a = 0; n_b = 0; n_c = 0;
        mode = md; tap_count = CW'(n); ptr_a_init = pa; ptr_b_init = pb;
        buf_base = b; buf_len = l; acc_continue = cont; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_cyc = 1;
        first_re_ok = dmem_a_re && busy;
        do begin
            @(negedge clk);
            got_cyc++;
            if (poke && got_cyc == 4) begin
                start = 1'b1; mode = ~md; tap_count = '0; acc_continue = ~cont;
                ptr_a_init = '0; buf_base = '0; buf_len = 8'd2;
            end else begin
                start = 1'b0;
            end
        end while (!done && got_cyc < 4000);
        got_acc = acc_out;
        @(negedge clk);
        done_width_ok = !done && !busy;
    endtask

    task automatic job_and_check(input string tag, input logic [1:0] md, input int n,
                                 input logic [AW-1:0] pa, input logic [AW-1:0] pb,
                                 input logic [AW-1:0] b, input logic [AW-1:0] l,
                                 input logic cont, input bit poke);
        logic [47:0] exp;
        int c;
        exp = model(md, n, pa, pb, b, l, cont, prev_acc);
        c = md[1] ? 3 : 2;
        run_job(md, n, pa, pb, b, l, cont, poke);
        check(tag, "result", 64'(got_acc), 64'(exp));
        check(md[1] ? "R4" : "R3", "cycles to done", 64'(got_cyc), 64'((n + 2) * c + 2));
        check("R8", "done one cycle", 64'(done_width_ok), 64'd1);
        check("R12", "first read after accept", 64'(first_re_ok), 64'd1);
        check("R1", "tap reads A", 64'(n_a), 64'(n + 2));
        if (md[0]) begin
            check("R6", "port B reads", 64'(n_b), 64'(n + 2));
            check("R6", "coef reads", 64'(n_c), 64'd0);
        end else begin
            check("R5", "port B reads", 64'(n_b), 64'd0);
            check("R5", "coef reads", 64'(n_c), 64'(n + 2));
        end
        prev_acc = exp;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < DEPTH; i++) begin
            dmem[i] = DW'($urandom);
            cmem[i] = DW'($urandom);
        end
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11", "busy", 64'(busy), 64'd0);
        check("R11", "done", 64'(done), 64'd0);
        check("R11", "acc_out", 64'(acc_out), 64'd0);
        check("R11", "read enables", 64'({dmem_a_re, dmem_b_re, cmem_re}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: each mode, small runs
        job_and_check("R1_R2", 2'b00, 3, 8'd40, 8'd100, 8'd32, 8'd20, 1'b0, 1'b0);
        job_and_check("R1_R2", 2'b01, 4, 8'd40, 8'd44, 8'd32, 8'd20, 1'b0, 1'b0);
        job_and_check("R1_R4", 2'b10, 2, 8'd33, 8'd7,  8'd32, 8'd20, 1'b0, 1'b0);
        job_and_check("R1_R4", 2'b11, 5, 8'd35, 8'd50, 8'd32, 8'd20, 1'b0, 1'b0);
        // R7 wrap of both pointers in a short buffer
        job_and_check("R7", 2'b01, 6, 8'd24, 8'd21, 8'd16, 8'd10, 1'b0, 1'b0);
        job_and_check("R7", 2'b11, 3, 8'd25, 8'd16, 8'd16, 8'd10, 1'b0, 1'b0);
        // R9 continue on previous result, then clear
        job_and_check("R9", 2'b10, 1, 8'd60, 8'd90, 8'd50, 8'd30, 1'b1, 1'b0);
        job_and_check("R9", 2'b10, 1, 8'd60, 8'd90, 8'd50, 8'd30, 1'b0, 1'b0);
        // R10 start pulse mid-run has no effect
        job_and_check("R10", 2'b11, 4, 8'd70, 8'd74, 8'd66, 8'd16, 1'b0, 1'b1);
        job_and_check("R10", 2'b00, 6, 8'd70, 8'd10, 8'd66, 8'd16, 1'b0, 1'b1);

        // overflow corner: most negative operands, longest run
        for (int i = 0; i < DEPTH; i++) begin
            dmem[i] = 16'h8000;
            cmem[i] = 16'h8000;
        end
        job_and_check("R3", 2'b00, 255, 8'd0, 8'd0, 8'd0, 8'd254, 1'b0, 1'b0);
        check("R3", "wrapped sum", 64'(got_acc), 64'h4000_0000);
        job_and_check("R4", 2'b11, 255, 8'd0, 8'd2, 8'd0, 8'd254, 1'b0, 1'b0);
        check("R4", "48-bit sum", 64'(got_acc), 64'h40_4000_0000);

        // constrained random jobs
        for (int i = 0; i < DEPTH; i++) begin
            dmem[i] = DW'($urandom);
            cmem[i] = DW'($urandom);
        end
        for (int k = 0; k < 24; k++) begin
            int b, l, pa, pb, n;
            logic [1:0] md;
            b  = int'($urandom_range(0, 200));
            l  = 2 * int'($urandom_range(1, (DEPTH - b) / 2));
            pa = b + int'($urandom_range(0, l - 1));
            pb = b + int'($urandom_range(0, l - 1));
            if ($urandom_range(0, 1) == 0) pb = int'($urandom_range(0, DEPTH - 1));
            md = 2'($urandom);
            if (!md[0] && pb >= b + l) pb = pb; // coefficient pointer may lie anywhere
            if (md[0]) pb = b + ((pb - b) % l + l) % l;
            n  = int'($urandom_range(0, 30));
            job_and_check("R2", md, n, AW'(pa), AW'(pb), AW'(b), AW'(l),
                          1'($urandom_range(0, 1)), 1'b0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule